// File: doc/BRIEF.md
# GPIO Bank Register Port

This block holds the control state for one bank of general-purpose pins and exposes it through a small memory-mapped register bus. The bank has up to 32 pins. Each pin has four control bits: an output latch, a direction bit, a blink enable and an input polarity bit. The bank drives three signals per pin to the pad ring: an output value, an output enable and a raw pad input coming back. Pin multiplexing and interrupt generation live in neighbouring blocks.

Software reads the pad levels through a read-only data-in register. The raw pad levels first pass through a two-flop synchronizer. Each level is then XORed with its polarity bit, so an active-low line can be read as active-high. For output pins with blink enabled, the pad toggles instead of holding the latch value. All blinking pins share one square-wave phase that comes from a free-running counter, and the half-period of that counter is a parameter.

The bus works in single cycles. A write takes effect on the clock edge where `bus_wr` is high. A read is registered: the data appears on `bus_rdata` in the cycle after the edge that samples `bus_rd`, and `bus_rdata` is zero in every other cycle.

Top module: `gpio_bank_regs`

## Requirements
- R1: After a synchronous reset with `rst_n` low, the registers hold these values:
  - output latch: 0
  - direction: all ones, so every pin is an input
  - blink: 0
  - polarity: 0
  - the blink phase: 0
  - `bus_rdata`: 0
- R2: A write replaces the whole register at one of these byte addresses:
  - 0x00: output latch
  - 0x04: direction
  - 0x08: blink enable
  - 0x0C: polarity
  
  A read of the same address returns the stored value on `bus_rdata` one cycle after the edge that sampled `bus_rd`. When no read was sampled on the previous edge, `bus_rdata` is zero.
- R3: `pad_oe[i]` is the inverse of direction bit i: a 1 makes the pin an input and a 0 makes it an output.
- R4: `pad_out[i]` equals latch bit i XOR (blink bit i AND the phase). The phase starts at 0 after reset and inverts every `BLINK_HALF` clock edges. Pins whose blink bit is 0 hold their latch value.
- R5: A read of 0x10 returns the synchronized pad input XOR the polarity register. A change on `pad_in` applied before edge 1 is first seen by a read sampled on edge 3. Reads sampled on edges 1 and 2 still return the old level.
- R6: A write to the read-only address 0x10 changes no register.
- R7: A read of any address other than 0x00, 0x04, 0x08, 0x0C or 0x10 returns zero. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, zero when idle |
| pad_out | output | NUM_PINS | Value driven to each pad |
| pad_oe | output | NUM_PINS | Driver enable for each pad |
| pad_in | input | NUM_PINS | Raw level returned by each pad |

## Verification
The bench goes after the synchronizer depth by changing a pad and reading data-in on three edges in a row. A design with one flop too few or too many returns the new level one read early or one read late. It counts the toggles of blinking and non-blinking pins over a window of several half-periods. An off-by-one in the counter wrap changes the toggle cadence, and the cycle-by-cycle compare reports it. It also writes to the read-only address and to an unmapped address and then reads every register back. A decoder that aliases those addresses onto a real register shows up as a corrupted latch, direction, blink or polarity value.

// File: rtl/gpio_bank_pkg.sv
// Shared definitions for the GPIO bank register port.
// Assumes a byte-addressed bus with 32-bit data and word-aligned registers.
package gpio_bank_pkg;

    localparam int BUS_DW = 32;

    // Register byte offsets; software decodes these, so they are fixed.
    localparam logic [31:0] OFF_LATCH = 32'h00;
    localparam logic [31:0] OFF_DIR   = 32'h04;
    localparam logic [31:0] OFF_BLINK = 32'h08;
    localparam logic [31:0] OFF_POL   = 32'h0C;
    localparam logic [31:0] OFF_DIN   = 32'h10;

    // Number of writable control registers.
    localparam int NUM_CTRL = 4;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_LATCH = 3'd1,
        SEL_DIR   = 3'd2,
        SEL_BLINK = 3'd3,
        SEL_POL   = 3'd4,
        SEL_DIN   = 3'd5
    } reg_sel_e;

    // Map a zero-extended byte address to a register select.
    function automatic reg_sel_e decode_addr(input logic [31:0] a);
        reg_sel_e s;
        case (a)
            OFF_LATCH: s = SEL_LATCH;
            OFF_DIR:   s = SEL_DIR;
            OFF_BLINK: s = SEL_BLINK;
            OFF_POL:   s = SEL_POL;
            OFF_DIN:   s = SEL_DIN;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Select code of writable control register k.
    function automatic reg_sel_e ctrl_sel(input int k);
        reg_sel_e s;
        case (k)
            0:       s = SEL_LATCH;
            1:       s = SEL_DIR;
            2:       s = SEL_BLINK;
            default: s = SEL_POL;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
// Multi-stage synchronizer, one chain per bit.
// Assumes each bit is an independent level; no bus coherency is implied.
module gpio_bank_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw pad levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                // Later stages resolve metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_blink.sv
// Free-running blink phase generator shared by every pin of the bank.
// Assumes HALF >= 2; the phase inverts every HALF clock edges after reset.
module gpio_bank_blink #(
    parameter int HALF = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;

    // Count through one half-period and invert the phase on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/gpio_bank_csr.sv
// Writable control registers of the bank: latch, direction, blink, polarity.
// Assumes sel is already decoded; SEL_DIN and SEL_NONE write nothing.
module gpio_bank_csr
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  reg_sel_e            sel,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] latch,
    output logic [NUM_PINS-1:0] dir,
    output logic [NUM_PINS-1:0] blink,
    output logic [NUM_PINS-1:0] pol
);
    logic [NUM_PINS-1:0] ctrl_q [NUM_CTRL];

    genvar k;
    generate
        for (k = 0; k < NUM_CTRL; k++) begin : g_reg
            localparam reg_sel_e MY_SEL = ctrl_sel(k);
            localparam logic [NUM_PINS-1:0] RST_VAL =
                (MY_SEL == SEL_DIR) ? {NUM_PINS{1'b1}} : '0;
            // Load the whole register on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)                        ctrl_q[k] <= RST_VAL;
                else if (wr_en && sel == MY_SEL)   ctrl_q[k] <= wdata;
            end
        end
    endgenerate

    assign latch = ctrl_q[0];
    assign dir   = ctrl_q[1];
    assign blink = ctrl_q[2];
    assign pol   = ctrl_q[3];
endmodule

// File: rtl/gpio_bank_rdmux.sv
// Registered read multiplexer; returns zero when idle or unmapped.
// Assumes NUM_PINS <= BUS_DW; upper bits read as zero.
module gpio_bank_rdmux
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  reg_sel_e            sel,
    input  logic [NUM_PINS-1:0] latch,
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] blink,
    input  logic [NUM_PINS-1:0] pol,
    input  logic [NUM_PINS-1:0] din,
    output logic [BUS_DW-1:0]   rdata
);
    logic [NUM_PINS-1:0] pick;
    logic [BUS_DW-1:0]   rdata_q;

    // Choose the addressed register.
    always_comb begin
        case (sel)
            SEL_LATCH: pick = latch;
            SEL_DIR:   pick = dir;
            SEL_BLINK: pick = blink;
            SEL_POL:   pick = pol;
            SEL_DIN:   pick = din;
            default:   pick = '0;
        endcase
    end

    // Capture on a read strobe, otherwise return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= BUS_DW'(pick);
        else            rdata_q <= '0;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/gpio_bank_regs.sv
// GPIO bank register port: control registers, pad drive and data-in path.
// Assumes a single clock domain for the bus; pad inputs are asynchronous.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    parameter int ADDR_W     = 8,
    parameter int BLINK_HALF = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_rd,
    output logic [31:0]         bus_rdata,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    input  logic [NUM_PINS-1:0] pad_in
);
    reg_sel_e            sel;
    logic [NUM_PINS-1:0] latch, dir, blink, pol, pad_sync, din;
    logic                phase;

    assign sel = decode_addr(32'(bus_addr));

    gpio_bank_csr #(.NUM_PINS(NUM_PINS)) u_csr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata[NUM_PINS-1:0]),
        .latch (latch),
        .dir   (dir),
        .blink (blink),
        .pol   (pol)
    );

    gpio_bank_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    gpio_bank_blink #(.HALF(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    // Apply the per-pin polarity to the synchronized levels.
    always_comb din = pad_sync ^ pol;

    // Drive the pads: blinking pins follow the shared phase.
    always_comb begin
        pad_out = latch ^ (blink & {NUM_PINS{phase}});
        pad_oe  = ~dir;
    end

    gpio_bank_rdmux #(.NUM_PINS(NUM_PINS)) u_rdmux (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (bus_rd),
        .sel   (sel),
        .latch (latch),
        .dir   (dir),
        .blink (blink),
        .pol   (pol),
        .din   (din),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/gpio_bank_regs_chk.sv
// Port-level property checker for gpio_bank_regs, bound to every instance.
module gpio_bank_regs_chk #(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe
);
    logic armed;
    logic is_dir, is_mapped;

    // Arm the history-based checks one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    always_comb begin
        is_dir    = (32'(bus_addr) == 32'h04);
        is_mapped = (32'(bus_addr) == 32'h00) || (32'(bus_addr) == 32'h04) ||
                    (32'(bus_addr) == 32'h08) || (32'(bus_addr) == 32'h0C) ||
                    (32'(bus_addr) == 32'h10);
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0));

    assert_idle_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);

    assert_dir_read_vs_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_dir) |=> bus_rdata[NUM_PINS-1:0] == ~$past(pad_oe));

    assert_oe_held_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(bus_wr && is_dir) |-> $stable(pad_oe));

    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !is_mapped) |=> bus_rdata == '0);
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_bank_regs_tb.sv
module gpio_bank_regs_tb;
    localparam int NP   = 32;
    localparam int AW   = 8;
    localparam int HALF = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_out, pad_oe;
    logic [NP-1:0] pad_in = '0;

    int checks = 0;
    int errors = 0;

    gpio_bank_regs #(.NUM_PINS(NP), .ADDR_W(AW), .BLINK_HALF(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
    );

    always #10 clk = ~clk;

    // Behavioural reference model, updated on every rising edge.
    logic [31:0] m_latch, m_dir, m_blink, m_pol, m_s1, m_s2, m_rd;
    int          m_ticks;
    bit          m_valid = 0;

    always @(posedge clk) begin
        logic [31:0] nrd;
        if (!rst_n) begin
            m_latch = 0; m_dir = '1; m_blink = 0; m_pol = 0;
            m_s1 = 0; m_s2 = 0; m_rd = 0; m_ticks = 0; m_valid = 1;
        end else begin
            nrd = 0;
            if (bus_rd) begin
                case (int'(bus_addr))
                    'h00: nrd = m_latch;
                    'h04: nrd = m_dir;
                    'h08: nrd = m_blink;
                    'h0C: nrd = m_pol;
                    'h10: nrd = m_s2 ^ m_pol;
                    default: nrd = 0;
                endcase
            end
            if (bus_wr) begin
                case (int'(bus_addr))
                    'h00: m_latch = bus_wdata;
                    'h04: m_dir   = bus_wdata;
                    'h08: m_blink = bus_wdata;
                    'h0C: m_pol   = bus_wdata;
                    default: ;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
            m_ticks++;
            m_rd = nrd;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare the pad side and read data against the model on every cycle.
    always @(negedge clk) begin
        logic [31:0] ph;
        if (m_valid) begin
            ph = ((m_ticks / HALF) % 2) ? '1 : '0;
            chk("R3 pad_oe", pad_oe, ~m_dir);
            chk("R4 pad_out", pad_out, m_latch ^ (m_blink & ph));
            chk("R2/R5/R7 bus_rdata", bus_rdata, m_rd);
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Issue a read and return the data seen on the following cycle.
    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic readback(input string req, input logic [31:0] el,
                            input logic [31:0] ed, input logic [31:0] eb,
                            input logic [31:0] ep);
        logic [31:0] v;
        rd('h00, v); chk({req, " latch"}, v, el);
        rd('h04, v); chk({req, " dir"}, v, ed);
        rd('h08, v); chk({req, " blink"}, v, eb);
        rd('h0C, v); chk({req, " pol"}, v, ep);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic        prev0, prev4;
        int          tog0, tog4;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state through the bus and the pads.
        chk("R1 pad_oe after reset", pad_oe, '0);
        chk("R1 pad_out after reset", pad_out, '0);
        readback("R1", 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0);

        // R7: unmapped and misaligned reads return zero.
        rd('h14, v); chk("R7 unmapped 0x14", v, 0);
        rd('h02, v); chk("R7 misaligned 0x02", v, 0);
        rd('hFC, v); chk("R7 unmapped 0xFC", v, 0);

        // R2/R3: direction and latch writes.
        wr('h04, 32'h0000_FF0F);
        chk("R3 oe after dir write", pad_oe, 32'hFFFF_00F0);
        wr('h00, 32'hA5A5_5A5A);
        wr('h0C, 32'h0F0F_0F0F);
        readback("R2", 32'hA5A5_5A5A, 32'h0000_FF0F, 32'h0, 32'h0F0F_0F0F);

        // R4: blink pins 0 and 1; bit 4 stays static.
        wr('h08, 32'h0000_0003);
        tog0 = 0; tog4 = 0;
        @(negedge clk);
        prev0 = pad_out[0]; prev4 = pad_out[4];
        for (int i = 0; i < 4 * HALF; i++) begin
            @(negedge clk);
            if (pad_out[0] != prev0) tog0++;
            if (pad_out[4] != prev4) tog4++;
            prev0 = pad_out[0]; prev4 = pad_out[4];
        end
        chk("R4 blink toggles over 4 half-periods", tog0, 4);
        chk("R4 static pin toggles", tog4, 0);

        // R5: polarity applied to settled pad levels.
        pad_in = 32'h1234_5678;
        repeat (4) @(negedge clk);
        rd('h10, v); chk("R5 data-in with polarity", v, 32'h1234_5678 ^ 32'h0F0F_0F0F);
        wr('h0C, 32'h0);
        rd('h10, v); chk("R5 data-in polarity zero", v, 32'h1234_5678);

        // R5: two-flop latency, reads on edges 1..3 after the change.
        @(negedge clk);
        pad_in = 32'hCAFE_0001;
        bus_addr = AW'('h10); bus_rd = 1'b1;
        @(negedge clk); #1 chk("R5 sync edge1 old", bus_rdata, 32'h1234_5678);
        @(negedge clk); #1 chk("R5 sync edge2 old", bus_rdata, 32'h1234_5678);
        @(negedge clk); #1 chk("R5 sync edge3 new", bus_rdata, 32'hCAFE_0001);
        bus_rd = 1'b0;

        // R6: write to data-in address leaves every register unchanged.
        wr('h10, 32'hDEAD_BEEF);
        readback("R6", 32'hA5A5_5A5A, 32'h0000_FF0F, 32'h3, 32'h0);
        rd('h10, v); chk("R6 data-in unchanged", v, 32'hCAFE_0001);

        // R7: write to unmapped addresses leaves registers unchanged.
        wr('h14, 32'h1111_1111);
        wr('h01, 32'h2222_2222);
        readback("R7", 32'hA5A5_5A5A, 32'h0000_FF0F, 32'h3, 32'h0);

        // R1: mid-run reset returns to the reset state.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 pad_oe after second reset", pad_oe, '0);
        readback("R1 second", 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule